// File: doc/BRIEF.md
# Horizontal Sync Pulse Regenerator

This block takes a raw, asynchronous horizontal sync line and rebuilds from it a clean sync pulse in the pixel clock domain. The raw line first passes through a synchronizer. After that, only one transition counts as the start of a line: the one picked by an input-sense bit. The opposite transition is never used. Each accepted transition starts a new output pulse. The pulse width is counted out in pixel clocks from a programmed value, so it does not copy the width of the incoming pulse. The active level of the output is chosen by a second sense bit.

The regenerated pulse, and a one-clock strobe that marks its first cycle, go through an alignment delay. This delay matches the latency of the pixel data pipeline, so downstream logic sees sync and data in the same clock. Typical use is in a display capture path: the regenerated sync and strobe drive line counters and memory write addressing.

Top module: `hsync_regen`

## Requirements
- R1: While `rst_n` is low, and for the first four clocks after it rises, `sync_out` is at its inactive level (`!cfg_out_pol`) and `lead_strobe` is 0.
- R2: With `cfg_in_pol` = 1, a low-to-high transition of `sync_raw` is the active (leading) edge.
- R3: With `cfg_in_pol` = 0, a high-to-low transition of `sync_raw` is the active (leading) edge.
- R4: The transition of `sync_raw` opposite to the active one has no effect on `sync_out` or `lead_strobe`, whether it comes before or after the output pulse ends.
- R5: After an active edge, `sync_out` stays active for exactly `cfg_width` consecutive clocks, for any value from 1 to 255.
- R6: A `cfg_width` of 0 gives an active output of exactly one clock.
- R7: `sync_out` is high when active if `cfg_out_pol` = 1, and low when active if `cfg_out_pol` = 0.
- R8: The first active cycle of `sync_out` is sampled after the seventh rising clock edge that follows the active transition of `sync_raw`: two synchronizer stages, one pulse-generation stage and four alignment stages.
- R9: An active edge that arrives while a pulse is still being output restarts the count. The output stays active without a gap and ends `cfg_width` clocks after the new pulse start.
- R10: `lead_strobe` is high for exactly one clock per active edge, in the same clock as the first active cycle of the pulse it starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| sync_raw | input | 1 | Raw horizontal sync, asynchronous to `clk` |
| cfg_in_pol | input | 1 | Input sense: 1 selects the rising edge, 0 selects the falling edge |
| cfg_out_pol | input | 1 | Output sense: 1 gives active-high, 0 gives active-low |
| cfg_width | input | 8 | Output pulse width in clocks; 0 is treated as 1 |
| sync_out | output | 1 | Regenerated, delay-aligned sync pulse |
| lead_strobe | output | 1 | One-clock marker of the first cycle of each pulse |

## Verification
The assertions take four things for granted. The input line does not toggle on consecutive clocks. The width and sense settings stay constant while an edge moves through the pipeline. The raw line sits at its inactive level when reset is released. When the sense bit is flipped, the raw line is flipped with it, so the flip cannot look like a leading edge. The stimulus changes settings only while the line has been idle for many clocks, flips the input sense together with the raw level, and holds every raw high or low phase for at least one full clock. Under those conditions, two strobes can never occur on adjacent cycles, and every strobe lands on an active output cycle.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

   // One pipeline slot of the regenerated sync: leading-cycle marker plus level.
   typedef struct packed {
      logic lead;
      logic on;
   } hsr_evt_t;

   localparam hsr_evt_t HSR_EVT_IDLE = '{lead: 1'b0, on: 1'b0};

endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("hsr_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/hsr_edge.sv
module hsr_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic in_pol,
   output logic lead
);

   logic prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   // Active edge: the level has just reached the sense selected by in_pol.
   assign lead = (lvl == in_pol) && (prev != in_pol);

   // R4: the opposite transition never makes a second leading cycle right behind the first
   assert_single_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lead |=> !lead);

endmodule

// File: rtl/hsr_pulse.sv
module hsr_pulse
   import hsr_pkg::*;
#(
   parameter int W_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lead_in,
   input  logic [W_BITS-1:0] width,
   output hsr_evt_t          evt
);

   localparam logic [W_BITS-1:0] MIN_W = W_BITS'(1);

   logic [W_BITS-1:0] cnt;
   logic [W_BITS-1:0] eff_w;
   logic              lead_q;

   generate
      if (W_BITS < 1) begin : g_bad
         $error("hsr_pulse: W_BITS must be at least 1");
      end
   endgenerate

   assign eff_w = (width == '0) ? MIN_W : width;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         lead_q <= 1'b0;
      end else begin
         lead_q <= lead_in;
         if (lead_in)          cnt <= eff_w;
         else if (cnt != '0)   cnt <= cnt - MIN_W;
      end
   end

   assign evt.lead = lead_q;
   assign evt.on   = (cnt != '0);

   // R5: every accepted edge produces an active cycle next clock
   assert_edge_starts_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lead_in |=> evt.on);

   // R6: a zero width lasts one clock unless a fresh edge restarts it
   assert_zero_width_one_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_in && width == '0) |=> (evt.on ##1 (!evt.on || $past(lead_in))));

endmodule

// File: rtl/hsr_align.sv
module hsr_align
   import hsr_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  hsr_evt_t evt_in,
   output hsr_evt_t evt_out
);

   generate
      if (DEPTH < 0) begin : g_bad
         $error("hsr_align: DEPTH must not be negative");
      end

      if (DEPTH == 0) begin : g_pass
         assign evt_out = evt_in;
      end else begin : g_pipe
         hsr_evt_t pipe [DEPTH];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) pipe[i] <= HSR_EVT_IDLE;
            end else begin
               pipe[0] <= evt_in;
               for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
            end
         end

         assign evt_out = pipe[DEPTH-1];

         // R8: every slot advances unchanged by exactly one clock per stage
         assert_first_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
            pipe[0] == $past(evt_in));

         for (genvar k = 1; k < DEPTH; k++) begin : g_chk
            assert_stage_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
               pipe[k] == $past(pipe[k-1]));
         end
      end
   endgenerate

endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
   import hsr_pkg::*;
#(
   parameter int W_BITS      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ALIGN_DELAY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_raw,
   input  logic              cfg_in_pol,
   input  logic              cfg_out_pol,
   input  logic [W_BITS-1:0] cfg_width,
   output logic              sync_out,
   output logic              lead_strobe
);

   logic     lvl_s;
   logic     lead_c;
   hsr_evt_t evt_gen;
   hsr_evt_t evt_dly;

   hsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_raw),
      .q     (lvl_s)
   );

   hsr_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl_s),
      .in_pol (cfg_in_pol),
      .lead   (lead_c)
   );

   hsr_pulse #(.W_BITS(W_BITS)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .lead_in (lead_c),
      .width   (cfg_width),
      .evt     (evt_gen)
   );

   hsr_align #(.DEPTH(ALIGN_DELAY)) u_align (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_in  (evt_gen),
      .evt_out (evt_dly)
   );

   assign sync_out    = evt_dly.on ? cfg_out_pol : ~cfg_out_pol;
   assign lead_strobe = evt_dly.lead;

   // R10: the strobe always coincides with an active output cycle
   assert_strobe_on_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lead_strobe |-> (sync_out == cfg_out_pol));

   // R10: strobe never lasts two clocks
   assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lead_strobe |=> !lead_strobe);

endmodule

// File: tb/hsync_regen_tb_top.sv
`timescale 1ns/1ps
module hsync_regen_tb_top;

   localparam int LAT   = 2 + 4 + 1;   // R8: clock edges from raw edge to first active sample
   localparam int LIMIT = 200000;

   typedef struct {
      int start;
      int width;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_raw = 1'b0;
   logic       cfg_in_pol = 1'b1;
   logic       cfg_out_pol = 1'b1;
   logic [7:0] cfg_width = 8'd5;
   logic       sync_out;
   logic       lead_strobe;

   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   exp_t  q[$];
   int    cur_start = 0;
   int    cur_end = 0;
   bit    done = 1'b0;

   hsync_regen dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_raw    (sync_raw),
      .cfg_in_pol  (cfg_in_pol),
      .cfg_out_pol (cfg_out_pol),
      .cfg_width   (cfg_width),
      .sync_out    (sync_out),
      .lead_strobe (lead_strobe)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: pops expected pulse starts and compares both outputs every cycle.
   always @(negedge clk) begin
      bit exp_strobe;
      bit exp_act;
      logic exp_lvl;
      exp_strobe = 1'b0;
      while (q.size() > 0 && q[0].start <= cyc) begin
         if (q[0].start == cyc) exp_strobe = 1'b1;
         cur_start = q[0].start;
         cur_end   = q[0].start + q[0].width;   // R9: a later edge replaces the end
         void'(q.pop_front());
      end
      exp_act = (cyc >= cur_start) && (cyc < cur_end);
      exp_lvl = exp_act ? cfg_out_pol : ~cfg_out_pol;
      n_chk++;
      if (sync_out !== exp_lvl) begin
         n_fail++;
         $display("FAIL %s R8 sync_out cyc=%0d actual=%b expected=%b", cur_req, cyc, sync_out, exp_lvl);
      end
      n_chk++;
      if (lead_strobe !== exp_strobe) begin
         n_fail++;
         $display("FAIL %s R10 lead_strobe cyc=%0d actual=%b expected=%b", cur_req, cyc, lead_strobe, exp_strobe);
      end
   end

   // Driver: one active phase of hi clocks followed by gap idle clocks.
   task automatic send(input int hi, input int gap);
      exp_t e;
      e.start = cyc + LAT;
      e.width = (cfg_width == 8'd0) ? 1 : int'(cfg_width);   // R6
      q.push_back(e);
      sync_raw = cfg_in_pol;
      repeat (hi) @(negedge clk);
      sync_raw = ~cfg_in_pol;
      repeat (gap) @(negedge clk);
   endtask

   initial begin
      // R1: reset and first clocks after it
      cur_req = "R1";
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);

      // R2: rising edge active, pulse shorter than width
      cur_req = "R2";
      cfg_width = 8'd5;
      send(2, 20);

      // R4: input pulse longer than width, trailing edge after output ends
      cur_req = "R4";
      send(12, 20);

      // R6: width zero gives one clock
      cur_req = "R6";
      cfg_width = 8'd0;
      send(3, 15);

      // R5: maximum width
      cur_req = "R5";
      cfg_width = 8'd255;
      send(4, 270);
      cfg_width = 8'd9;
      send(1, 20);

      // R7: active-low output
      cur_req = "R7";
      cfg_out_pol = 1'b0;
      repeat (3) @(negedge clk);
      cfg_width = 8'd6;
      send(2, 20);

      // R3: falling edge active; sense and raw level flip together
      cur_req = "R3";
      cfg_out_pol = 1'b1;
      cfg_in_pol  = 1'b0;
      sync_raw    = 1'b1;
      repeat (10) @(negedge clk);
      cfg_width = 8'd4;
      send(3, 20);
      send(8, 20);

      // R9: a new edge during an active pulse restarts the count
      cur_req = "R9";
      cfg_width = 8'd20;
      send(3, 5);
      send(3, 40);

      // R10: dense edges, each with its own one-clock strobe
      cur_req = "R10";
      cfg_width = 8'd1;
      send(1, 1);
      send(1, 1);
      send(1, 2);
      send(1, 25);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired at cyc=%0d actual=running expected=finished", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule